// File: doc/BRIEF.md
# Washer Program Sequencer with Countdown

This block sequences a simple automatic washing machine through its wash, rinse and spin phases. A program key steps through five fixed phase programs, and a start/pause key launches the chosen program, freezes it and resumes it. While a phase runs, the block counts its remaining seconds down on two BCD digits and lights that phase's indicator. When the last phase of the program ends, the block returns to its idle stop state.

The block expects already debounced, single-cycle key pulses and a one-cycle-wide one-second tick, all synchronous to `clk`. Clock division, key conditioning, seven-segment decoding and digit multiplexing belong to neighbouring blocks.

Top module: `washer_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state code goes to 000 (stop), the program code to 000, both count digits to 0 and all phase indicators turn off.
- R2: A program-key pulse in the stop (000) or selection (001) state moves the state to selection (001) and advances the program code 001, 010, 011, 100, 101 and back to 001. From 000 it goes to 001. The codes mean: 001 wash only, 010 rinse only, 011 spin only, 100 rinse then spin, 101 wash then rinse then spin.
- R3: A program-key pulse in a phase state (010, 011 or 100) leaves the program code unchanged.
- R4: A start pulse in stop or selection, with a program code from 001 to 101, enters that program's first phase with its full duration loaded: wash is state 010 for 20 s, rinse is 011 for 15 s, spin is 100 for 10 s.
- R5: While a phase runs, each tick lowers the count by exactly one. The count is shown as a tens digit and a ones digit, each from 0 to 9.
- R6: On the tick that would bring the count to zero, the program's next phase is entered on that same tick with its full duration. Each phase therefore shows its duration down to 1 for one tick each.
- R7: On the tick that would bring the last phase's count to zero, the state goes to stop (000), the count to 00 and all indicators turn off. The program code is kept.
- R8: A start/pause pulse during a phase pauses it. While paused, ticks change neither state nor count, and the phase indicator is off. A further pulse resumes the same phase from the same count.
- R9: A start pulse in stop with program code 000 is ignored: the state stays 000 and the count 00.
- R10: The phase indicators are one-hot while running: bit 0 is wash, bit 1 is rinse and bit 2 is spin. Otherwise all indicators are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| mode_key | input | 1 | Debounced program-select pulse |
| run_key | input | 1 | Debounced start/pause/resume pulse |
| state_code | output | 3 | 000 stop, 001 selection, 010 wash, 011 rinse, 100 spin |
| prog_code | output | 3 | Selected program, 000 none, 001 to 101 |
| cnt_tens | output | 4 | BCD tens digit of the remaining seconds |
| cnt_ones | output | 4 | BCD ones digit of the remaining seconds |
| phase_led | output | 3 | Running-phase indicators: bit 0 wash, bit 1 rinse, bit 2 spin |

## Verification
All five programs are run to completion. The single-phase programs show that each phase has its own duration and ends in stop. The two multi-phase programs show that phase hand-off happens on the expiring tick, with no extra second at 00. The countdown passes borrows from 20 to 19 and from 10 to 9, which separates a correct BCD borrow from a plain binary decrement. A pause in the middle of a phase, with ticks and program-key pulses given while paused, separates a true freeze-and-restore from a restart. A start pulse given straight after reset, and program-key pulses given during a run, show which key pulses are ignored in which states.

// File: rtl/washer_pkg.sv
// Shared types and phase-ordering helpers for the washer sequencer.
// Assumes state and program codes are consumed externally as plain 3-bit codes.
package washer_pkg;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_MODE  = 3'd1,
        ST_WASH  = 3'd2,
        ST_RINSE = 3'd3,
        ST_SPIN  = 3'd4
    } wstate_t;

    typedef enum logic [2:0] {
        PG_NONE  = 3'd0,
        PG_WASH  = 3'd1,
        PG_RINSE = 3'd2,
        PG_SPIN  = 3'd3,
        PG_RSPIN = 3'd4,
        PG_FULL  = 3'd5
    } wprog_t;

    localparam int NUM_PHASES = 3;

    // First phase that a program enters on start
    function automatic wstate_t first_phase(input wprog_t prog);
        case (prog)
            PG_WASH, PG_FULL:  return ST_WASH;
            PG_RINSE, PG_RSPIN: return ST_RINSE;
            PG_SPIN:           return ST_SPIN;
            default:           return ST_STOP;
        endcase
    endfunction

    // Phase following the current one within a program, or stop
    function automatic wstate_t next_phase(input wprog_t prog, input wstate_t st);
        case (st)
            ST_WASH:  return (prog == PG_FULL) ? ST_RINSE : ST_STOP;
            ST_RINSE: return (prog == PG_RSPIN || prog == PG_FULL) ? ST_SPIN : ST_STOP;
            default:  return ST_STOP;
        endcase
    endfunction

endpackage

// File: rtl/washer_prog_sel.sv
// Program selection register.
// Advances cyclically 001..101 on each accepted advance pulse; from 000 goes to 001.
// Assumes the caller has already qualified the advance pulse by state.
module washer_prog_sel
    import washer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    output wprog_t prog
);

    wprog_t prog_q;

    // Hold or advance the selected program
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= PG_NONE;
        end else if (adv) begin
            if (prog_q == PG_FULL || prog_q == PG_NONE)
                prog_q <= PG_WASH;
            else
                prog_q <= wprog_t'(prog_q + 3'd1);
        end
    end

    assign prog = prog_q;

endmodule

// File: rtl/washer_bcd_timer.sv
// Loadable BCD down-counter of DIGITS decimal digits.
// Load has priority over decrement; decrement at 0 is never requested by the sequencer.
// Assumes load_val fits in DIGITS decimal digits.
module washer_bcd_timer #(
    parameter int DIGITS = 2,
    parameter int VALW   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [VALW-1:0]     load_val,
    input  logic                dec,
    output logic [DIGITS*4-1:0] bcd,
    output logic                at_one
);

    localparam int BW = DIGITS * 4;

    logic [3:0]    dig_q   [DIGITS];
    logic          zero_lo [DIGITS+1];
    logic [BW-1:0] load_bcd;

    // Binary to BCD conversion of the load value
    function automatic logic [BW-1:0] to_bcd(input logic [VALW-1:0] v);
        logic [BW-1:0] res;
        int unsigned   r;
        res = '0;
        r   = int'(v);
        for (int i = 0; i < DIGITS; i++) begin
            res[i*4 +: 4] = 4'(r % 10);
            r = r / 10;
        end
        return res;
    endfunction

    assign load_bcd   = to_bcd(load_val);
    assign zero_lo[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        // Borrow chain: this digit moves only when all lower digits are zero
        assign zero_lo[g+1] = zero_lo[g] && (dig_q[g] == 4'd0);

        // Per-digit load or decimal decrement with wrap 0 -> 9
        always_ff @(posedge clk) begin
            if (!rst_n)
                dig_q[g] <= 4'd0;
            else if (load)
                dig_q[g] <= load_bcd[g*4 +: 4];
            else if (dec && zero_lo[g])
                dig_q[g] <= (dig_q[g] == 4'd0) ? 4'd9 : dig_q[g] - 4'd1;
        end

        assign bcd[g*4 +: 4] = dig_q[g];
    end

    assign at_one = (bcd == BW'(1));

endmodule

// File: rtl/washer_phase_fsm.sv
// Phase sequencer: stop / selection / wash / rinse / spin with a pause flag.
// Drives load and decrement requests to the BCD timer and the program-advance pulse.
// Assumes key and tick inputs are single-cycle pulses; start/pause wins over program key.
module washer_phase_fsm
    import washer_pkg::*;
#(
    parameter int WASH_SEC  = 20,
    parameter int RINSE_SEC = 15,
    parameter int SPIN_SEC  = 10,
    parameter int VALW      = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sec_tick,
    input  logic            mode_key,
    input  logic            run_key,
    input  wprog_t          prog,
    input  logic            at_one,
    output wstate_t         state,
    output logic            paused,
    output logic            prog_adv,
    output logic            tmr_load,
    output logic [VALW-1:0] tmr_val,
    output logic            tmr_dec
);

    wstate_t state_q, state_d, nxt;
    logic    paused_q, paused_d;
    logic    idle, in_phase, start_ok, mode_ok, step;

    // Full duration of a phase in seconds
    function automatic logic [VALW-1:0] dur_of(input wstate_t st);
        case (st)
            ST_WASH:  return VALW'(WASH_SEC);
            ST_RINSE: return VALW'(RINSE_SEC);
            ST_SPIN:  return VALW'(SPIN_SEC);
            default:  return '0;
        endcase
    endfunction

    assign idle     = (state_q == ST_STOP) || (state_q == ST_MODE);
    assign in_phase = (state_q == ST_WASH) || (state_q == ST_RINSE) || (state_q == ST_SPIN);
    assign start_ok = idle && run_key && (prog != PG_NONE);
    assign mode_ok  = idle && mode_key && !run_key;
    assign step     = in_phase && !paused_q && sec_tick && !run_key;
    assign nxt      = next_phase(prog, state_q);

    // Next-state and timer-request decode
    always_comb begin
        state_d  = state_q;
        paused_d = paused_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        if (start_ok) begin
            state_d  = first_phase(prog);
            paused_d = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = dur_of(first_phase(prog));
        end else if (mode_ok) begin
            state_d = ST_MODE;
        end else if (in_phase && run_key) begin
            paused_d = !paused_q;
        end else if (step) begin
            if (at_one) begin
                state_d  = nxt;
                tmr_load = 1'b1;
                tmr_val  = dur_of(nxt);
            end else begin
                tmr_dec = 1'b1;
            end
        end
    end

    // State and pause-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_STOP;
            paused_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            paused_q <= paused_d;
        end
    end

    assign state    = state_q;
    assign paused   = paused_q;
    assign prog_adv = mode_ok;

endmodule

// File: rtl/washer_seq.sv
// Washer program sequencer top: program register, phase FSM and two-digit BCD countdown.
// Assumes a synchronous one-second tick and debounced single-cycle key pulses.
module washer_seq
    import washer_pkg::*;
#(
    parameter int WASH_SEC  = 20,
    parameter int RINSE_SEC = 15,
    parameter int SPIN_SEC  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       mode_key,
    input  logic       run_key,
    output logic [2:0] state_code,
    output logic [2:0] prog_code,
    output logic [3:0] cnt_tens,
    output logic [3:0] cnt_ones,
    output logic [2:0] phase_led
);

    localparam int DIGITS  = 2;
    localparam int MAX_SEC = (WASH_SEC > RINSE_SEC)
                           ? ((WASH_SEC > SPIN_SEC) ? WASH_SEC : SPIN_SEC)
                           : ((RINSE_SEC > SPIN_SEC) ? RINSE_SEC : SPIN_SEC);
    localparam int VALW    = $clog2(MAX_SEC + 1);

    wprog_t              prog;
    wstate_t             state;
    logic                paused, prog_adv, tmr_load, tmr_dec, at_one;
    logic [VALW-1:0]     tmr_val;
    logic [DIGITS*4-1:0] bcd;

    washer_prog_sel u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (prog_adv),
        .prog  (prog)
    );

    washer_phase_fsm #(
        .WASH_SEC  (WASH_SEC),
        .RINSE_SEC (RINSE_SEC),
        .SPIN_SEC  (SPIN_SEC),
        .VALW      (VALW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .mode_key (mode_key),
        .run_key  (run_key),
        .prog     (prog),
        .at_one   (at_one),
        .state    (state),
        .paused   (paused),
        .prog_adv (prog_adv),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec)
    );

    washer_bcd_timer #(
        .DIGITS (DIGITS),
        .VALW   (VALW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .bcd      (bcd),
        .at_one   (at_one)
    );

    // Phase indicators: bit i lit while phase ST_WASH+i runs unpaused
    always_comb begin
        for (int i = 0; i < NUM_PHASES; i++)
            phase_led[i] = !paused && (state == wstate_t'(3'(int'(ST_WASH) + i)));
    end

    assign state_code = state;
    assign prog_code  = prog;
    assign cnt_tens   = bcd[7:4];
    assign cnt_ones   = bcd[3:0];

endmodule

// File: rtl/washer_seq_chk.sv
// Property checker for washer_seq, attached through bind.
// Observes only the top-level ports.
module washer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       mode_key,
    input logic       run_key,
    input logic [2:0] state_code,
    input logic [2:0] prog_code,
    input logic [3:0] cnt_tens,
    input logic [3:0] cnt_ones,
    input logic [2:0] phase_led
);

    logic in_phase;
    assign in_phase = (state_code >= 3'd2) && (state_code <= 3'd4);

    p_led_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_led));

    p_state_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd4);

    p_bcd_digit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tens <= 4'd9) && (cnt_ones <= 4'd9));

    p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0) |-> (cnt_tens == 4'd0 && cnt_ones == 4'd0 && phase_led == 3'd0));

    p_mode_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase && mode_key) |=> $stable(prog_code));

    p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase && phase_led == 3'd0 && !run_key)
            |=> ($stable(state_code) && $stable(cnt_tens) && $stable(cnt_ones)));

    p_no_prog_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && prog_code == 3'd0 && run_key) |=> (state_code == 3'd0));

endmodule

bind washer_seq washer_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .mode_key   (mode_key),
    .run_key    (run_key),
    .state_code (state_code),
    .prog_code  (prog_code),
    .cnt_tens   (cnt_tens),
    .cnt_ones   (cnt_ones),
    .phase_led  (phase_led)
);

// File: tb/sim_washer_seq.sv
// Directed bench for washer_seq: one task per scenario, each checking its own results.
module sim_washer_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       mode_key = 1'b0;
    logic       run_key = 1'b0;
    logic [2:0] state_code, prog_code, phase_led;
    logic [3:0] cnt_tens, cnt_ones;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    washer_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .mode_key   (mode_key),
        .run_key    (run_key),
        .state_code (state_code),
        .prog_code  (prog_code),
        .cnt_tens   (cnt_tens),
        .cnt_ones   (cnt_ones),
        .phase_led  (phase_led)
    );

    // Single check with failure report
    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int count_now();
        return int'(cnt_tens) * 10 + int'(cnt_ones);
    endfunction

    function automatic int dur(input int st);
        case (st)
            2: return 20;
            3: return 15;
            4: return 10;
            default: return 0;
        endcase
    endfunction

    // Phase sequence of a program: idx 0..2, 0 when none
    function automatic int phase_of(input int p, input int idx);
        case (p)
            1: return (idx == 0) ? 2 : 0;
            2: return (idx == 0) ? 3 : 0;
            3: return (idx == 0) ? 4 : 0;
            4: return (idx == 0) ? 3 : (idx == 1) ? 4 : 0;
            5: return (idx < 3) ? idx + 2 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic pulse_mode();
        @(negedge clk); mode_key = 1'b1;
        @(negedge clk); mode_key = 1'b0;
    endtask

    task automatic pulse_run();
        @(negedge clk); run_key = 1'b1;
        @(negedge clk); run_key = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic select_prog(input int p);
        for (int i = 0; i < 6 && int'(prog_code) != p; i++) pulse_mode();
        chk("R2 selected program", int'(prog_code), p);
    endtask

    task automatic t_reset();
        chk("R1 state after reset", int'(state_code), 0);
        chk("R1 program after reset", int'(prog_code), 0);
        chk("R1 count after reset", count_now(), 0);
        chk("R1 leds after reset", int'(phase_led), 0);
    endtask

    task automatic t_start_without_prog();
        pulse_run();
        chk("R9 state after start with no program", int'(state_code), 0);
        chk("R9 count after start with no program", count_now(), 0);
        tick();
        chk("R9 count after tick in stop", count_now(), 0);
    endtask

    task automatic t_mode_cycle();
        int exp_seq[6] = '{1, 2, 3, 4, 5, 1};
        for (int i = 0; i < 6; i++) begin
            pulse_mode();
            chk("R2 program advance", int'(prog_code), exp_seq[i]);
            chk("R2 selection state", int'(state_code), 1);
        end
    endtask

    // Run a program to completion, checking every second and each hand-off
    task automatic t_run_program(input int p, input bit poke_mode);
        select_prog(p);
        pulse_run();
        for (int idx = 0; idx < 3; idx++) begin
            int st;
            st = phase_of(p, idx);
            if (st == 0) break;
            chk("R4 R6 phase state", int'(state_code), st);
            chk("R4 R6 full duration loaded", count_now(), dur(st));
            chk("R10 phase led", int'(phase_led), 1 << (st - 2));
            for (int k = 1; k < dur(st); k++) begin
                tick();
                chk("R5 countdown", count_now(), dur(st) - k);
                if (poke_mode && k == 3) begin
                    pulse_mode();
                    chk("R3 program unchanged during phase", int'(prog_code), p);
                    chk("R3 state unchanged during phase", int'(state_code), st);
                end
            end
            tick();
        end
        chk("R7 stop after program", int'(state_code), 0);
        chk("R7 count cleared", count_now(), 0);
        chk("R7 leds off", int'(phase_led), 0);
        chk("R7 program kept", int'(prog_code), p);
    endtask

    task automatic t_pause_resume();
        select_prog(1);
        pulse_run();
        repeat (3) tick();
        chk("R5 count before pause", count_now(), 17);
        pulse_run();
        chk("R8 led off while paused", int'(phase_led), 0);
        chk("R8 state held while paused", int'(state_code), 2);
        repeat (5) tick();
        chk("R8 count frozen while paused", count_now(), 17);
        pulse_mode();
        chk("R3 program unchanged while paused", int'(prog_code), 1);
        pulse_run();
        chk("R8 resumed phase", int'(state_code), 2);
        chk("R8 resumed count", count_now(), 17);
        chk("R10 led back on", int'(phase_led), 1);
        tick();
        chk("R8 countdown after resume", count_now(), 16);
        repeat (16) tick();
        chk("R7 stop after resumed program", int'(state_code), 0);
    endtask

    task automatic t_restart_from_stop();
        chk("R4 in stop with program kept", int'(state_code), 0);
        pulse_run();
        chk("R4 restart from stop", int'(state_code), 4);
        chk("R4 restart duration", count_now(), 10);
        repeat (10) tick();
        chk("R7 stop after restart", int'(state_code), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_without_prog();
        t_mode_cycle();
        t_run_program(1, 1'b0);
        t_run_program(2, 1'b0);
        t_run_program(3, 1'b0);
        t_restart_from_stop();
        t_run_program(4, 1'b1);
        t_run_program(5, 1'b1);
        t_pause_resume();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule